// File: doc/BRIEF.md
# Highway and Farm-Road Crossing Signal Controller

This block sequences the lights at a crossing between a busy highway and a quiet farm road. The highway keeps right of way by default. The farm road gets a green phase only when a vehicle is waiting there and the highway has already held green for a minimum interval. Each change of right of way passes through a yellow phase. The yellow phase lasts a shorter, fixed interval.

An interval timer sits inside the block. It restarts on every phase change and on reset. It raises a short-done flag and a long-done flag once the parameterised cycle counts `SHORT_CYC` and `LONG_CYC` have elapsed since that restart. The block shows each restart to the outside as a one-cycle start pulse. Both light outputs are registered, and reset is synchronous.

Top module: `xing_signal_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are highway green with farm red, and `tmr_start` is 1, whatever the previous phase.
- R2: The light codes are 2'b00 red, 2'b01 yellow and 2'b10 green. The only output pairs (highway, farm) are (10,00), (01,00), (00,10) and (00,01).
- R3: Highway green changes to highway yellow only when `car_wait` is 1 and at least `LONG_CYC` cycles have passed in highway green. The first cycle of a phase counts as cycle 0, so highway green lasts at least `LONG_CYC`+1 cycles.
- R4: Highway yellow lasts exactly `SHORT_CYC`+1 cycles and then changes to highway red with farm green.
- R5: Farm green changes to farm yellow at the first edge where `car_wait` is 0 or `LONG_CYC` cycles have passed in farm green. Otherwise it holds.
- R6: Farm yellow lasts exactly `SHORT_CYC`+1 cycles and then returns to highway green.
- R7: `tmr_start` is 1 for exactly the first cycle of each new phase and for the cycle after a reset edge. It is 0 in every other cycle.
- R8: The highway and the farm road are never both non-red in the same cycle.
- R9: Reset takes priority over a timer-driven change that is due in the same cycle.
- R10: The interval count restarts from zero on every phase entry, so a dwell never reuses time spent in an earlier phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| car_wait | input | 1 | Vehicle present on the farm road |
| hwy_light | output | 2 | Highway light code (registered) |
| farm_light | output | 2 | Farm-road light code (registered) |
| tmr_start | output | 1 | One-cycle pulse: interval timer restarted |

## Verification
The bound checker tests the following on every cycle:
- the two roads are never both non-red at once;
- a light change is always accompanied by the start pulse;
- a start pulse that does not follow a reset always comes with a light change;
- each phase may only move to its allowed successor;
- highway green holds when no car waits;
- farm green is left immediately when the road is empty.

The dwell lengths depend on the parameterised intervals and on how far the input history reaches back, so only the bench's reference model can confirm them. The same applies to a reset that lands in the very cycle a yellow phase expires.

// File: rtl/xing_pkg.sv
package xing_pkg;

   typedef enum logic [1:0] {
      LAMP_RED = 2'b00,
      LAMP_YEL = 2'b01,
      LAMP_GRN = 2'b10
   } lamp_e;

   typedef enum logic [1:0] {
      PH_HWY_GO,
      PH_HWY_WARN,
      PH_FARM_GO,
      PH_FARM_WARN
   } phase_e;

endpackage

// File: rtl/xing_interval_timer.sv
module xing_interval_timer #(
   parameter int LONG_CYC  = 20,
   parameter int SHORT_CYC = 4
) (
   input  logic clk,
   input  logic restart,
   output logic long_done,
   output logic short_done
);
   localparam int CW = $clog2(LONG_CYC + 1);
   localparam logic [CW-1:0] LONG_LIM  = CW'(LONG_CYC);
   localparam logic [CW-1:0] SHORT_LIM = CW'(SHORT_CYC);

   // elaboration-time parameter checks
   if (SHORT_CYC < 1) begin : g_bad_short
      $error("SHORT_CYC must be at least 1");
   end
   if (LONG_CYC <= SHORT_CYC) begin : g_bad_long
      $error("LONG_CYC must exceed SHORT_CYC");
   end

   logic [CW-1:0] cnt_q;

   // saturating count of cycles since the last restart
   always_ff @(posedge clk) begin
      if (restart)
         cnt_q <= '0;
      else if (cnt_q != LONG_LIM)
         cnt_q <= cnt_q + CW'(1);
   end

   assign long_done  = (cnt_q >= LONG_LIM);
   assign short_done = (cnt_q >= SHORT_LIM);
endmodule

// File: rtl/xing_phase_fsm.sv
module xing_phase_fsm
   import xing_pkg::*;
(
   input  logic   clk,
   input  logic   rst,
   input  logic   car_wait,
   input  logic   long_done,
   input  logic   short_done,
   output phase_e phase_nxt,
   output logic   move
);
   phase_e phase_q;

   always_comb begin
      phase_nxt = phase_q;
      if (rst) begin
         phase_nxt = PH_HWY_GO;
      end else begin
         unique case (phase_q)
            PH_HWY_GO:    if (car_wait && long_done)   phase_nxt = PH_HWY_WARN;
            PH_HWY_WARN:  if (short_done)              phase_nxt = PH_FARM_GO;
            PH_FARM_GO:   if (!car_wait || long_done)  phase_nxt = PH_FARM_WARN;
            PH_FARM_WARN: if (short_done)              phase_nxt = PH_HWY_GO;
            default:                                   phase_nxt = PH_HWY_GO;
         endcase
      end
   end

   // reset counts as a restart even when the phase is unchanged
   assign move = rst || (phase_nxt != phase_q);

   always_ff @(posedge clk) begin
      phase_q <= phase_nxt;
   end
endmodule

// File: rtl/xing_lamp_drive.sv
module xing_lamp_drive
   import xing_pkg::*;
(
   input  logic       clk,
   input  phase_e     phase_nxt,
   output logic [1:0] hwy_light,
   output logic [1:0] farm_light
);
   lamp_e hwy_d, farm_d;

   always_comb begin
      hwy_d  = LAMP_RED;
      farm_d = LAMP_RED;
      unique case (phase_nxt)
         PH_HWY_GO:    hwy_d  = LAMP_GRN;
         PH_HWY_WARN:  hwy_d  = LAMP_YEL;
         PH_FARM_GO:   farm_d = LAMP_GRN;
         PH_FARM_WARN: farm_d = LAMP_YEL;
         default:      hwy_d  = LAMP_GRN;
      endcase
   end

   always_ff @(posedge clk) begin
      hwy_light  <= hwy_d;
      farm_light <= farm_d;
   end
endmodule

// File: rtl/xing_signal_ctrl.sv
module xing_signal_ctrl
   import xing_pkg::*;
#(
   parameter int LONG_CYC  = 20,
   parameter int SHORT_CYC = 4
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       car_wait,
   output logic [1:0] hwy_light,
   output logic [1:0] farm_light,
   output logic       tmr_start
);
   logic   long_done, short_done, move;
   phase_e phase_nxt;

   xing_interval_timer #(
      .LONG_CYC  (LONG_CYC),
      .SHORT_CYC (SHORT_CYC)
   ) u_timer (
      .clk        (clk),
      .restart    (move),
      .long_done  (long_done),
      .short_done (short_done)
   );

   xing_phase_fsm u_fsm (
      .clk        (clk),
      .rst        (rst),
      .car_wait   (car_wait),
      .long_done  (long_done),
      .short_done (short_done),
      .phase_nxt  (phase_nxt),
      .move       (move)
   );

   xing_lamp_drive u_lamp (
      .clk        (clk),
      .phase_nxt  (phase_nxt),
      .hwy_light  (hwy_light),
      .farm_light (farm_light)
   );

   // start pulse lines up with the cleared count in the new phase
   always_ff @(posedge clk) begin
      tmr_start <= move;
   end
endmodule

// File: rtl/xing_signal_chk.sv
module xing_signal_chk (
   input logic       clk,
   input logic       rst,
   input logic       car_wait,
   input logic [1:0] hwy_light,
   input logic [1:0] farm_light,
   input logic       tmr_start
);
   AST_RESET_STATE: assert property (@(posedge clk)
      rst |=> (hwy_light == 2'b10 && farm_light == 2'b00 && tmr_start)); // R1

   AST_LEGAL_CODES: assert property (@(posedge clk) disable iff (rst)
      (hwy_light != 2'b11 && farm_light != 2'b11)); // R2

   AST_NO_CONFLICT: assert property (@(posedge clk) disable iff (rst)
      (hwy_light == 2'b00 || farm_light == 2'b00)); // R8

   AST_HWY_HOLD: assert property (@(posedge clk) disable iff (rst)
      (hwy_light == 2'b10 && !car_wait) |=> (hwy_light == 2'b10)); // R3

   AST_HWY_WARN_NEXT: assert property (@(posedge clk) disable iff (rst)
      (hwy_light == 2'b01) |=> (hwy_light == 2'b01 || farm_light == 2'b10)); // R4

   AST_FARM_EMPTY_EXIT: assert property (@(posedge clk) disable iff (rst)
      (farm_light == 2'b10 && !car_wait) |=> (farm_light == 2'b01)); // R5

   AST_FARM_WARN_NEXT: assert property (@(posedge clk) disable iff (rst)
      (farm_light == 2'b01) |=> (farm_light == 2'b01 || hwy_light == 2'b10)); // R6

   AST_CHANGE_PULSE: assert property (@(posedge clk) disable iff (rst)
      (hwy_light != $past(hwy_light) || farm_light != $past(farm_light)) |-> tmr_start); // R7

   AST_PULSE_CHANGE: assert property (@(posedge clk) disable iff (rst)
      (tmr_start && !$past(rst)) |->
         (hwy_light != $past(hwy_light) || farm_light != $past(farm_light))); // R10
endmodule

bind xing_signal_ctrl xing_signal_chk u_chk (.*);

// File: tb/xing_signal_ctrl_tb.sv
module xing_signal_ctrl_tb_top;
   localparam int L = 8;
   localparam int S = 3;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       car_wait = 1'b0;
   logic [1:0] hwy_light, farm_light;
   logic       tmr_start;

   int checks = 0, fails = 0;
   bit cmp_en = 1'b0;
   bit done = 1'b0;

   // reference model
   int    m_state = 0;          // 0 HG, 1 HY, 2 FG, 3 FY
   int    m_cnt = 0;
   bit    m_start = 1'b1;
   string m_tag = "R1";

   always #10 clk = ~clk;       // 50 MHz

   xing_signal_ctrl #(.LONG_CYC(L), .SHORT_CYC(S)) dut_i (
      .clk(clk), .rst(rst), .car_wait(car_wait),
      .hwy_light(hwy_light), .farm_light(farm_light), .tmr_start(tmr_start)
   );

   function automatic logic [1:0] exp_hwy(int st);
      return (st == 0) ? 2'b10 : (st == 1) ? 2'b01 : 2'b00;
   endfunction
   function automatic logic [1:0] exp_farm(int st);
      return (st == 2) ? 2'b10 : (st == 3) ? 2'b01 : 2'b00;
   endfunction

   always @(posedge clk) begin
      int  ns;
      bit  due;
      case (m_state)
         0: ns = (car_wait && m_cnt >= L) ? 1 : 0;
         1: ns = (m_cnt >= S) ? 2 : 1;
         2: ns = (!car_wait || m_cnt >= L) ? 3 : 2;
         default: ns = (m_cnt >= S) ? 0 : 3;
      endcase
      due = (ns != m_state);
      if (rst) begin
         m_tag = due ? "R9" : "R1";
         ns = 0;
      end else begin
         case (m_state)
            0: m_tag = "R3";
            1: m_tag = "R4";
            2: m_tag = "R5";
            default: m_tag = "R6";
         endcase
      end
      m_start = rst || (ns != m_state);
      if (m_start) m_cnt = 0;
      else if (m_cnt < L) m_cnt++;
      m_state = ns;
   end

   task automatic chk(string tag, logic [1:0] act, logic [1:0] exp, string what);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_en) begin
         chk(m_tag, hwy_light, exp_hwy(m_state), "hwy_light");
         chk(m_tag, farm_light, exp_farm(m_state), "farm_light");
         chk("R7", {1'b0, tmr_start}, {1'b0, m_start}, "tmr_start");
         chk("R8", {1'b0, (hwy_light != 2'b00) && (farm_light != 2'b00)}, 2'b00, "both roads non-red");
      end
   end

   task automatic cycles(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      int dwell;
      cycles(3);
      cmp_en = 1'b1;
      // R2: reset codes at the ports
      chk("R2", hwy_light, 2'b10, "reset hwy code");
      chk("R2", farm_light, 2'b00, "reset farm code");
      @(negedge clk) rst = 1'b0;
      // R3: empty farm road keeps highway green
      cycles(20);
      chk("R3", hwy_light, 2'b10, "hold without car");
      car_wait = 1'b1;
      while (hwy_light != 2'b01) @(negedge clk);
      dwell = 0;
      while (hwy_light == 2'b01) begin dwell++; @(negedge clk); end
      // R10: yellow dwell counted from its own entry
      chk("R10", dwell[1:0], 2'(S + 1), "highway yellow dwell");
      chk("R4", farm_light, 2'b10, "farm green after yellow");
      cycles(3);
      car_wait = 1'b0;
      cycles(2);
      chk("R5", farm_light, 2'b01, "farm yellow when road empties");
      while (farm_light == 2'b01) @(negedge clk);
      chk("R6", hwy_light, 2'b10, "back to highway green");
      // R5 long interval with a car still waiting
      car_wait = 1'b1;
      cycles(60);
      // R9: reset in the cycle the highway yellow expires
      while (hwy_light != 2'b01) @(negedge clk);
      cycles(S);
      rst = 1'b1;
      @(negedge clk) rst = 1'b0;
      chk("R9", hwy_light, 2'b10, "reset beats due change");
      // reset while farm green
      while (farm_light != 2'b10) @(negedge clk);
      rst = 1'b1;
      @(negedge clk) rst = 1'b0;
      chk("R1", farm_light, 2'b00, "reset from farm green");
      // mixed traffic
      for (int i = 0; i < 400; i++) begin
         car_wait = ($urandom % 4) != 0;
         if (($urandom % 97) == 0) rst = 1'b1;
         @(negedge clk);
         rst = 1'b0;
      end
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog R7 actual=running expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule